// File: doc/BRIEF.md
# Center-of-Height Defuzzifier

This block turns the firing strengths of a set of output membership functions into one crisp 8-bit value. It uses the center-of-height weighted average: each output function has a peak position, and the result is the sum of peak times strength divided by the sum of strengths. Functions with zero strength add nothing to either sum. If no function fires, the result is zero and a flag reports that no rule fired.

Output functions are defined one at a time through a write port. Each definition is a shape kind (triangle or trapezoid) and a 32-bit breakpoint word. The block keeps only the peak position it derives from each definition.

A computation starts with a one-cycle start request while the block reports ready. The block latches the strength vector and then walks through the functions, one per cycle, building both sums. A restoring divider then forms the quotient, one bit per cycle. A single-cycle done pulse marks the result, which sits in the low byte of a 32-bit output word.

Top module: `cohd_defuzz`

## Requirements
- R1: The peak position depends on the shape kind and on two fields of the breakpoint word. The fields are b = bits [23:16] and c = bits [15:8]. A triangle (shape_trap=0) has its peak at b. A trapezoid (shape_trap=1) has its peak at floor((b+c)/2).
- R2: The crisp result is floor(Σ peak·strength / Σ strength), saturated to 255. Function i's strength is strengths[8i+7:8i], and the vector is sampled on the cycle that start is accepted.
- R3: When every strength is zero, the crisp result is 0 and none_fired is 1. Otherwise none_fired is 0.
- R4: crisp_word[31:8] is always zero, and crisp_word[7:0] holds the crisp result.
- R5: ready is high while idle and goes low on the cycle after start is accepted. A start raised while ready is low is ignored.
- R6: done is high for exactly one cycle per accepted start, and it is high in the cycle ready returns high. crisp_word and none_fired change only in that cycle.
- R7: A shape write is ignored while ready is low, and it is ignored when shape_idx is 15 or greater.
- R8: After reset, ready=1, done=0, none_fired=0, crisp_word=0, and every stored peak is 0.
- R9: Take a triangle (10,40,60) as function 0, with strength 171 on it and all other strengths 0. The result is 40.
- R10: done arrives no later than 15+20 cycles after start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shape_we | input | 1 | Write one output function definition |
| shape_idx | input | 4 | Index of the function being written |
| shape_trap | input | 1 | 1 = trapezoid, 0 = triangle |
| shape_word | input | 32 | Breakpoints a,b,c,d, from the most significant byte down |
| strengths | input | 120 | Fifteen 8-bit firing strengths, function 0 lowest |
| start | input | 1 | Request a computation |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse: a new result is valid |
| none_fired | output | 1 | The last result had all strengths zero |
| crisp_word | output | 32 | Crisp result in bits [7:0], upper bits zero |

## Verification
The bench sweeps the b and c fields over a grid for both shape kinds. A design that swapped the fields, or rounded the trapezoid midpoint up, would then return a wrong peak for a single firing function. Mixed patterns include many zero strengths and all-full strengths. They catch an accumulator that is too narrow or a divider that drops its last quotient bit, either of which would bias or wrap the average. An all-zero vector must give 0 together with the flag rather than a divide-by-zero value. The bench also pokes the block while it is busy: it changes the strengths, sends writes, and sends starts. A block that did not latch its inputs, or that accepted these, would report a wrong result or a second done pulse.

// File: rtl/cohd_pkg.sv
package cohd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SUM  = 2'd1,
        PH_DIV  = 2'd2
    } cohd_phase_e;
endpackage

// File: rtl/cohd_peak_store.sv
module cohd_peak_store #(
    parameter int NUM_FN = 15,
    parameter int W      = 8,
    parameter int IDXW   = $clog2(NUM_FN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_trap,
    input  logic [W-1:0]    wr_b,
    input  logic [W-1:0]    wr_c,
    input  logic [IDXW-1:0] rd_idx,
    output logic [W-1:0]    rd_peak
);
    logic [W:0]   mid_sum;
    logic [W-1:0] new_peak;
    logic [W-1:0] peak_d [NUM_FN];
    logic [W-1:0] peak_q [NUM_FN];

    always_comb begin
        mid_sum  = {1'b0, wr_b} + {1'b0, wr_c};
        new_peak = wr_trap ? mid_sum[W:1] : wr_b;
    end

    for (genvar i = 0; i < NUM_FN; i++) begin : g_entry
        always_comb begin
            peak_d[i] = peak_q[i];
            if (wr_en && (wr_idx == IDXW'(i))) begin
                peak_d[i] = new_peak;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) peak_q[i] <= '0;
            else        peak_q[i] <= peak_d[i];
        end
    end

    always_comb begin
        rd_peak = '0;
        for (int j = 0; j < NUM_FN; j++) begin
            if (rd_idx == IDXW'(j)) rd_peak = peak_q[j];
        end
    end
endmodule

// File: rtl/cohd_divstep.sv
module cohd_divstep #(
    parameter int DENW = 12
) (
    input  logic [DENW-1:0] rem_i,
    input  logic            bit_i,
    input  logic [DENW-1:0] den_i,
    output logic [DENW-1:0] rem_o,
    output logic            q_o
);
    logic [DENW:0] trial;
    logic [DENW:0] diff;

    always_comb begin
        trial = {rem_i, bit_i};
        diff  = trial - {1'b0, den_i};
        if (trial >= {1'b0, den_i}) begin
            q_o   = 1'b1;
            rem_o = diff[DENW-1:0];
        end else begin
            q_o   = 1'b0;
            rem_o = trial[DENW-1:0];
        end
    end
endmodule

// File: rtl/cohd_defuzz.sv
module cohd_defuzz
    import cohd_pkg::*;
#(
    parameter int NUM_FN = 15,
    parameter int W      = 8,
    parameter int IDXW   = $clog2(NUM_FN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shape_we,
    input  logic [IDXW-1:0]     shape_idx,
    input  logic                shape_trap,
    input  logic [4*W-1:0]      shape_word,
    input  logic [NUM_FN*W-1:0] strengths,
    input  logic                start,
    output logic                ready,
    output logic                done,
    output logic                none_fired,
    output logic [31:0]         crisp_word
);
    localparam int ACCW = 2 * W + IDXW;
    localparam int DENW = W + IDXW;
    localparam int CNTW = $clog2(ACCW + 1);

    typedef struct packed {
        cohd_phase_e         ph;
        logic [IDXW-1:0]     idx;
        logic [CNTW-1:0]     cnt;
        logic [ACCW-1:0]     num;
        logic [DENW-1:0]     den;
        logic [DENW-1:0]     rem;
        logic [NUM_FN*W-1:0] str;
        logic [W-1:0]        crisp;
        logic                none;
        logic                done;
    } cohd_state_t;

    cohd_state_t st_d, st_q;

    logic [W-1:0]    peak_rd;
    logic [W-1:0]    cur_str;
    logic [2*W-1:0]  prod;
    logic [ACCW-1:0] num_sum;
    logic [DENW-1:0] den_sum;
    logic [DENW-1:0] rem_nx;
    logic            q_bit;
    logic [ACCW-1:0] quot;

    cohd_peak_store #(.NUM_FN(NUM_FN), .W(W), .IDXW(IDXW)) u_peaks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (shape_we && (st_q.ph == PH_IDLE)),
        .wr_idx  (shape_idx),
        .wr_trap (shape_trap),
        .wr_b    (shape_word[3*W-1:2*W]),
        .wr_c    (shape_word[2*W-1:W]),
        .rd_idx  (st_q.idx),
        .rd_peak (peak_rd)
    );

    cohd_divstep #(.DENW(DENW)) u_step (
        .rem_i (st_q.rem),
        .bit_i (st_q.num[ACCW-1]),
        .den_i (st_q.den),
        .rem_o (rem_nx),
        .q_o   (q_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cur_str   = st_q.str[W-1:0];
        prod      = peak_rd * cur_str;
        num_sum   = st_q.num + ACCW'(prod);
        den_sum   = st_q.den + DENW'(cur_str);
        quot      = {st_q.num[ACCW-2:0], q_bit};

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_SUM;
                    st_d.idx = '0;
                    st_d.num = '0;
                    st_d.den = '0;
                    st_d.str = strengths;
                end
            end
            PH_SUM: begin
                st_d.num = num_sum;
                st_d.den = den_sum;
                st_d.str = st_q.str >> W;
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == IDXW'(NUM_FN - 1)) begin
                    if (den_sum == '0) begin
                        st_d.ph    = PH_IDLE;
                        st_d.crisp = '0;
                        st_d.none  = 1'b1;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.ph  = PH_DIV;
                        st_d.cnt = CNTW'(ACCW - 1);
                        st_d.rem = '0;
                    end
                end
            end
            PH_DIV: begin
                st_d.rem = rem_nx;
                st_d.num = quot;
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == '0) begin
                    st_d.ph    = PH_IDLE;
                    st_d.none  = 1'b0;
                    st_d.done  = 1'b1;
                    st_d.crisp = (quot > ACCW'({W{1'b1}})) ? {W{1'b1}} : quot[W-1:0];
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = (st_q.ph == PH_IDLE);
    assign done       = st_q.done;
    assign none_fired = st_q.none;
    assign crisp_word = {{(32 - W){1'b0}}, st_q.crisp};
endmodule

// File: rtl/cohd_defuzz_chk.sv
module cohd_defuzz_chk #(
    parameter int NUM_FN = 15,
    parameter int W      = 8,
    parameter int IDXW   = $clog2(NUM_FN + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        ready,
    input logic        done,
    input logic        none_fired,
    input logic [31:0] crisp_word
);
    localparam int ACCW  = 2 * W + IDXW;
    localparam int LIMIT = NUM_FN + ACCW;

    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (ready) busy_cnt <= '0;
        else            busy_cnt <= busy_cnt + 1'b1;
    end

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        crisp_word[31:W] == '0);

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (!done || 1'b1) && ($stable(crisp_word) || done));

    p_none_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        none_fired |-> (crisp_word == 32'd0));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 16'(LIMIT));
endmodule

bind cohd_defuzz cohd_defuzz_chk #(.NUM_FN(NUM_FN), .W(W), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready      (ready),
    .done       (done),
    .none_fired (none_fired),
    .crisp_word (crisp_word)
);

// File: tb/cohd_defuzz_tb.sv
module cohd_defuzz_tb;
    localparam int NF = 15;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shape_we = 1'b0;
    logic [3:0]    shape_idx = '0;
    logic          shape_trap = 1'b0;
    logic [31:0]   shape_word = '0;
    logic [NF*W-1:0] strengths = '0;
    logic          start = 1'b0;
    logic          ready, done, none_fired;
    logic [31:0]   crisp_word;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int pk [NF];
    int seed = 12345;

    cohd_defuzz u_dut (
        .clk(clk), .rst_n(rst_n), .shape_we(shape_we), .shape_idx(shape_idx),
        .shape_trap(shape_trap), .shape_word(shape_word), .strengths(strengths),
        .start(start), .ready(ready), .done(done), .none_fired(none_fired),
        .crisp_word(crisp_word)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic wr(input int idx, input bit trap, input int a, input int b,
                      input int c, input int d, input bit model);
        @(negedge clk);
        shape_we   = 1'b1;
        shape_idx  = 4'(idx);
        shape_trap = trap;
        shape_word = {8'(a), 8'(b), 8'(c), 8'(d)};
        @(negedge clk);
        shape_we = 1'b0;
        if (model && idx < NF) pk[idx] = trap ? (b + c) / 2 : b;
    endtask

    task automatic run(input logic [NF*W-1:0] s, input string req, input bit poke);
        longint num = 0;
        longint den = 0;
        longint exp;
        int n = 0;
        logic [31:0] held;
        for (int i = 0; i < NF; i++) begin
            num += longint'(pk[i]) * longint'(s[i*W +: W]);
            den += longint'(s[i*W +: W]);
        end
        exp = (den == 0) ? 0 : num / den;
        if (exp > 255) exp = 255;
        @(negedge clk);
        strengths = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R5 ready low after start", ready, 0);
        if (poke) begin
            // R5 start while busy ignored, R7 write while busy ignored, R2 strengths latched
            start      = 1'b1;
            strengths  = ~s;
            shape_we   = 1'b1;
            shape_idx  = 4'd0;
            shape_trap = 1'b0;
            shape_word = 32'h00_C8_00_00;
            @(negedge clk);
            start    = 1'b0;
            shape_we = 1'b0;
            n++;
        end
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R6 done seen", done, 1);
        chk(n <= NF + 20, "R10 latency", n, NF + 20);
        chk(crisp_word[7:0] == 8'(exp), req, crisp_word[7:0], exp);
        chk(crisp_word[31:8] == 24'd0, "R4 upper bits", crisp_word[31:8], 0);
        chk(none_fired == (den == 0), "R3 none_fired", none_fired, den == 0);
        chk(ready == 1'b1, "R6 ready with done", ready, 1);
        held = crisp_word;
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        @(negedge clk);
        chk(ready == 1'b1 && crisp_word == held, "R5 R6 idle and held", crisp_word, held);
    endtask

    initial begin
        logic [NF*W-1:0] s;
        for (int i = 0; i < NF; i++) pk[i] = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(ready == 1'b1, "R8 ready", ready, 1);
        chk(done == 1'b0, "R8 done", done, 0);
        chk(none_fired == 1'b0, "R8 none_fired", none_fired, 0);
        chk(crisp_word == 32'd0, "R8 crisp_word", crisp_word, 0);
        rst_n = 1'b1;
        // R8 stored peaks zero: every function full strength, average of zeros
        run({NF{8'hFF}}, "R8 peaks zero", 1'b0);
        // R3 nothing fired
        run('0, "R3 all zero", 1'b0);
        // R9 worked example
        wr(0, 1'b0, 10, 40, 60, 0, 1'b1);
        s = '0;
        s[7:0] = 8'd171;
        run(s, "R9 worked example", 1'b0);
        // R1 peak sweep on function 0, single strength
        for (int b = 0; b < 256; b += 17) begin
            for (int c = 0; c < 256; c += 17) begin
                wr(0, 1'b0, 0, b, c, 255, 1'b1);
                s = '0;
                s[7:0] = 8'(1 + ((b + c) & 8'hFE));
                run(s, "R1 triangle peak", 1'b0);
                wr(0, 1'b1, 0, b, c, 255, 1'b1);
                run(s, "R1 trapezoid peak", 1'b0);
            end
        end
        // R1 odd trapezoid sum truncates
        wr(0, 1'b1, 0, 254, 255, 255, 1'b1);
        s = '0;
        s[7:0] = 8'd9;
        run(s, "R1 trapezoid truncation", 1'b0);
        // load all functions
        for (int i = 0; i < NF; i++) begin
            wr(i, (i % 2) == 1, 0, (i * 53 + 7) & 255, (i * 91 + 200) & 255, 255, 1'b1);
        end
        // R7 out-of-range index ignored
        wr(15, 1'b0, 0, 255, 255, 255, 1'b0);
        run({NF{8'hFF}}, "R7 index 15 ignored R2 full", 1'b0);
        // R2 mixed patterns with sparse zeros
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < NF; i++) begin
                int r = rnd();
                s[i*W +: W] = ((r & 3) == 0) ? 8'd0 : 8'(r >> 2);
            end
            run(s, "R2 weighted average", (t % 10) == 0);
        end
        // R2 single maximum-strength peaks at the extremes
        wr(3, 1'b0, 0, 255, 0, 0, 1'b1);
        wr(4, 1'b0, 0, 0, 0, 0, 1'b1);
        s = '0;
        s[3*W +: W] = 8'd255;
        s[4*W +: W] = 8'd1;
        run(s, "R2 extreme peaks", 1'b1);
        // R7 busy write did not land
        s = '0;
        s[7:0] = 8'd5;
        run(s, "R7 busy write ignored", 1'b0);
        finish_run();
    end
endmodule